// File: doc/BRIEF.md
# Stride-1 Two-by-Two Max Pooling Engine

This engine walks a signed result image held in a linearly addressed memory whose rows sit a fixed pitch apart (128 words by default). At every window position it fetches the four words of a 2x2 neighbourhood and keeps the largest one. It then writes that value to a separate output memory. The window moves one column per step. Past the last usable column it drops one row and starts again at column zero, so neighbouring windows overlap.

A pulse on `start` begins a scan. The engine reads through a synchronous port with one cycle of latency. It writes one result per window, pulses `finished` in the cycle after each write, and raises `done` once the final window has been written. The input has a valid region of `VALID_W` x `VALID_H` pixels (126 x 126 by default). That region yields `(VALID_W-1)` x `(VALID_H-1)` results.

Top module: `max_pool_2x2`

## Requirements
- R1: While reset is held and in the cycle after it is released, `done`, `finished`, `wr_en` and `rd_en` are all 0.
- R2: For a window whose top-left pixel is at address a, the written value is the largest of the words at a, a+1, a+PITCH and a+PITCH+1. Read data is taken one cycle after `rd_en`, and no read leaves the valid region.
- R3: Operands are compared as two's-complement signed numbers of width DW. Every negative value ranks below every non-negative value, and in an all-negative window the result is the least negative value.
- R4: Windows are processed in row-major order. The column advances by one per window. After column VALID_W-2, the next window is column 0 of the next row.
- R5: The result for window (r,c) is written at address r*PITCH+c. A scan makes exactly (VALID_W-1)*(VALID_H-1) writes.
- R6: `finished` is high for exactly one cycle, in the cycle immediately after each `wr_en` cycle, and at no other time.
- R7: `done` rises after the last window's `finished` pulse and stays high, with no reads or writes, until `start` is seen. A `start` in that state clears `done` and runs a new full scan.
- R8: A `start` pulse during a scan has no effect: the order, addresses and number of writes are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a scan when idle or done |
| rd_en | output | 1 | Read request to the input memory |
| rd_addr | output | ADDR_W | Input memory read address |
| rd_data | input | DW | Read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Write strobe to the output memory |
| wr_addr | output | ADDR_W | Output memory write address, r*PITCH+c |
| wr_data | output | DW | Largest of the four window operands |
| finished | output | 1 | One-cycle pulse after each result write |
| done | output | 1 | High after the last window, until the next start |

## Verification
Four ramp images are built so that the largest operand always lands in one chosen corner of every window: bottom-right, top-left, bottom-left and top-right. A result that matches all four shows that each operand offset is fetched and steered correctly. An all-negative ramp and a mixed-sign pattern separate a signed compare from an unsigned one. The unused columns past the valid region hold the largest positive value, so any read outside the region shows up in the results. Further scans pulse `start` in the middle of a scan and after `done`, which tests that a busy start is ignored and that a new scan starts cleanly.

// File: rtl/pool_pkg.sv
// Shared types for the max pooling engine.
// Assumes: four operands per window, indexed in the order a, a+1, a+PITCH, a+PITCH+1.
package pool_pkg;
    localparam int NUM_OPS = 4;

    typedef logic [1:0] op_idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_DRAIN,
        ST_WRITE,
        ST_PULSE,
        ST_DONE
    } pool_state_t;
endpackage

// File: rtl/pool_scan.sv
// Window position generator: keeps the row and column of the current window
// and forms the top-left linear address row*PITCH+col.
// Assumes: step is never raised on the last window, so the counters stay in range.
module pool_scan #(
    parameter int PITCH   = 128,
    parameter int VALID_W = 126,
    parameter int VALID_H = 126,
    parameter int ADDR_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] base,
    output logic              last
);
    localparam int OUT_W = VALID_W - 1;
    localparam int OUT_H = VALID_H - 1;
    localparam int CW    = (OUT_W > 1) ? $clog2(OUT_W) : 1;
    localparam int RW    = (OUT_H > 1) ? $clog2(OUT_H) : 1;

    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic          at_edge;

    assign at_edge = (col == CW'(OUT_W - 1));
    assign last    = at_edge && (row == RW'(OUT_H - 1));
    assign base    = ADDR_W'(int'(row) * PITCH + int'(col));

    // Advance the window one column, wrapping to the next row at the right edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            col <= '0;
            row <= '0;
        end else if (step) begin
            if (at_edge) begin
                col <= '0;
                row <= row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    a_r4_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(col) <= OUT_W - 1);
    a_r4_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(row) <= OUT_H - 1);
    a_r4_wrap_to_left: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && at_edge) |=> (col == '0));
endmodule

// File: rtl/pool_opbuf.sv
// Operand bank: holds the four window operands, loading one slot per
// returned read word.
// Assumes: load and idx arrive in the cycle the memory data is valid.
module pool_opbuf
    import pool_pkg::*;
#(
    parameter int DW = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  op_idx_t                    idx,
    input  logic [DW-1:0]              din,
    output logic [NUM_OPS-1:0][DW-1:0] ops
);
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_slot
        // Capture the returned word into the slot it was requested for.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ops[i] <= '0;
            else if (load && (idx == op_idx_t'(i)))
                ops[i] <= din;
        end
    end
endmodule

// File: rtl/pool_max4.sv
// Two-level signed maximum over four operands. On a tie the earlier operand
// is kept (the value is identical).
// Assumes: operands are two's-complement numbers of width DW.
module pool_max4
    import pool_pkg::*;
#(
    parameter int DW = 20
) (
    input  logic [NUM_OPS-1:0][DW-1:0] ops,
    output logic [DW-1:0]              max_o
);
    logic [1:0][DW-1:0] lvl1;

    for (genvar i = 0; i < 2; i++) begin : g_pair
        // First level: pick the larger operand of each pair.
        always_comb begin
            if ($signed(ops[2*i+1]) > $signed(ops[2*i]))
                lvl1[i] = ops[2*i+1];
            else
                lvl1[i] = ops[2*i];
        end
    end

    // Second level: pick the larger of the two pair winners.
    always_comb begin
        if ($signed(lvl1[1]) > $signed(lvl1[0]))
            max_o = lvl1[1];
        else
            max_o = lvl1[0];
    end
endmodule

// File: rtl/max_pool_2x2.sv
// Stride-1 2x2 max pooling engine. It reads four operands per window through
// a one-cycle-latency port, writes the maximum to the output memory, pulses
// finished after each write and holds done after the last window.
// Assumes: the input and output memories are separate, and rd_data is valid
// exactly one cycle after rd_en.
module max_pool_2x2
    import pool_pkg::*;
#(
    parameter int DW      = 20,
    parameter int PITCH   = 128,
    parameter int VALID_W = 126,
    parameter int VALID_H = 126,
    parameter int ADDR_W  = $clog2(PITCH * VALID_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              finished,
    output logic              done
);
    localparam int IMG_WORDS = PITCH * VALID_H;

    pool_state_t               state;
    op_idx_t                   k;
    logic                      cap_vld;
    op_idx_t                   cap_idx;
    logic [ADDR_W-1:0]         base;
    logic                      last;
    logic                      scan_clr;
    logic                      scan_step;
    logic [NUM_OPS-1:0][DW-1:0] ops;
    logic [ADDR_W-1:0]         op_off;

    assign scan_clr  = start && (state == ST_IDLE || state == ST_DONE);
    assign scan_step = (state == ST_PULSE) && !last;

    assign op_off   = (k[1] ? ADDR_W'(PITCH) : '0) + ADDR_W'(k[0]);
    assign rd_en    = (state == ST_READ);
    assign rd_addr  = base + op_off;
    assign wr_en    = (state == ST_WRITE);
    assign wr_addr  = base;
    assign finished = (state == ST_PULSE);
    assign done     = (state == ST_DONE);

    pool_scan #(
        .PITCH(PITCH), .VALID_W(VALID_W), .VALID_H(VALID_H), .ADDR_W(ADDR_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .clr(scan_clr), .step(scan_step),
        .base(base), .last(last)
    );

    pool_opbuf #(.DW(DW)) u_opbuf (
        .clk(clk), .rst_n(rst_n), .load(cap_vld), .idx(cap_idx),
        .din(rd_data), .ops(ops)
    );

    pool_max4 #(.DW(DW)) u_max (.ops(ops), .max_o(wr_data));

    // Sequence each window: four reads, drain the last return, write, pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            k     <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: if (start) begin
                    state <= ST_READ;
                    k     <= '0;
                end
                ST_READ: begin
                    k <= k + 1'b1;
                    if (k == op_idx_t'(NUM_OPS - 1)) state <= ST_DRAIN;
                end
                ST_DRAIN: state <= ST_WRITE;
                ST_WRITE: state <= ST_PULSE;
                ST_PULSE: begin
                    k     <= '0;
                    state <= last ? ST_DONE : ST_READ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Tag the read issued this cycle so its data is captured one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_vld <= rd_en;
            cap_idx <= k;
        end
    end

    a_r6_fin_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> finished);
    a_r6_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
        finished |=> !finished);
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !rd_en));
    a_r2_rd_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (int'(rd_addr) < IMG_WORDS));
    a_r2_data_captured: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> cap_vld);
endmodule

// File: tb/sim_max_pool_2x2.sv
module sim_max_pool_2x2;
    localparam int DW = 12;
    localparam int P  = 16;
    localparam int VW = 10;
    localparam int VH = 7;
    localparam int AW = $clog2(P * VH);
    localparam int NWIN = (VW - 1) * (VH - 1);
    localparam logic signed [DW-1:0] BIG = {1'b0, {(DW-1){1'b1}}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_en, wr_en, finished, done;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic signed [DW-1:0] mem_in [0:P*VH-1];

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    max_pool_2x2 #(.DW(DW), .PITCH(P), .VALID_W(VW), .VALID_H(VH)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .finished(finished), .done(done)
    );

    always_ff @(posedge clk)
        rd_data <= (int'(rd_addr) < P * VH) ? mem_in[rd_addr] : 'x;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [DW-1:0] exp_max(input int r, input int c);
        int a = r * P + c;
        logic signed [DW-1:0] m = mem_in[a];
        if (mem_in[a + 1] > m) m = mem_in[a + 1];
        if (mem_in[a + P] > m) m = mem_in[a + P];
        if (mem_in[a + P + 1] > m) m = mem_in[a + P + 1];
        return m;
    endfunction

    // kind: 0 ramp up, 1 ramp down (negative), 2 row up col down, 3 row down col up, 4 mixed
    task automatic fill(input int kind);
        for (int r = 0; r < VH; r++)
            for (int c = 0; c < P; c++) begin
                int v;
                case (kind)
                    0: v = r * P + c;
                    1: v = -(r * P + c) - 1;
                    2: v = r * 20 - c;
                    3: v = -r * 20 + c;
                    default: v = ((r * 7 + c * 3) % 11) * 150 - 700;
                endcase
                mem_in[r * P + c] = (c >= VW) ? BIG : DW'(v);
            end
    endtask

    // Run one scan and check each write in order; poke_busy pulses start mid-scan.
    task automatic run_scan(input string req, input bit poke_busy);
        int idx = 0;
        bit pend = 0;
        bit poked = 0;
        int t = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(done == 1'b0, "R7", "done cleared by start", int'(done), 0);
        while (!done && t < 3000) begin
            if (pend) begin
                check(finished == 1'b1, "R6", "finished after write", int'(finished), 1);
                pend = 0;
            end else if (finished) begin
                check(1'b0, "R6", "stray finished", 1, 0);
            end
            if (wr_en) begin
                int r = idx / (VW - 1);
                int c = idx % (VW - 1);
                check(int'(wr_addr) == r * P + c, "R4 R5", "write address",
                      int'(wr_addr), r * P + c);
                check($signed(wr_data) == exp_max(r, c), req, "window max",
                      int'($signed(wr_data)), int'(exp_max(r, c)));
                idx++;
                pend = 1;
            end
            start = (poke_busy && idx == 5 && !poked) ? 1'b1 : 1'b0;
            if (start) poked = 1;
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        check(done == 1'b1, "R7", "done reached", int'(done), 1);
        check(idx == NWIN, poke_busy ? "R8" : "R5", "write count", idx, NWIN);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(!done && !finished && !wr_en && !rd_en, "R1", "outputs in reset",
              int'({done, finished, wr_en, rd_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !finished && !wr_en && !rd_en, "R1", "outputs after reset",
              int'({done, finished, wr_en, rd_en}), 0);
    endtask

    task automatic t_corners;
        fill(0); run_scan("R2", 1'b0);
        fill(2); run_scan("R2", 1'b0);
        fill(3); run_scan("R2", 1'b0);
    endtask

    task automatic t_signed;
        fill(1); run_scan("R3", 1'b0);
        fill(4); run_scan("R3", 1'b0);
    endtask

    task automatic t_done_hold;
        repeat (10) begin
            @(negedge clk);
            check(done && !wr_en && !rd_en && !finished, "R7", "idle while done",
                  int'({done, wr_en, rd_en, finished}), 8);
        end
    endtask

    task automatic t_busy_start;
        fill(4); run_scan("R8", 1'b1);
    endtask

    initial begin
        t_reset();
        t_corners();
        t_done_hold();
        t_signed();
        t_busy_start();
        t_done_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule